// File: doc/BRIEF.md
# Dual-Mode Fixed-Point Instruction Decoder

This block takes one 32-bit instruction word per cycle and turns it into a micro-operation record for an execution backend. The record gives the operation class and the destination and source register indices. It also gives a fully formed immediate, the adder carry-in source, and separate write enables for the destination register, the carry flag, the overflow flag and one condition-register field. Decoding is combinational. The record is captured in one register stage, so each word appears on the outputs one clock after it is presented.

A one-bit mode input, driven from a machine state bit, selects which instruction set the word belongs to. In the 64-bit-style mode (`arch_riscv_i` low) the block decodes the fixed-point subset in full: arithmetic with immediate and register operands, compare, and logical operations. In the other mode it recognises nothing yet, and every valid word is reported as illegal. The immediate is widened to a parameterised datapath width `XLEN`, which must be at least 32.

Top module: `fxu_decode`

## Requirements
- R1: A word sampled with `in_valid_i` high at a rising edge appears on the outputs after that edge with `out_valid_o` high. When `in_valid_i` is low, `out_valid_o`, `illegal_o` and all write enables are low after the edge.
- R2: With `arch_riscv_i` high, every valid word gives `illegal_o`=1. In that case `op_o`=0, all write enables are 0 and `imm_o`=0.
- R3: A word is illegal when its primary opcode (bits 31:26) is not 7, 8, 11, 12, 13, 14, 15, 24..29 or 31, or when opcode 31 carries an unlisted extended code. Compare with bit 0 set is illegal, and so is the extended-add form with a carry field (bits 10:9) other than 1. Illegal words give the same outputs as in R2.
- R4: Opcode 14 (op 1, add) and opcode 15 (op 1) write the register named in bits 25:21, as does opcode 7 (op 4, multiply). These forms raise no flag enables, and `cin_sel_o`=0 (constant zero).
- R5: Opcode 12 (op 1) and opcode 13 (op 1) set `ca_we_o`. So does opcode 8 (op 2, subtract-from, with `cin_sel_o`=1, constant one). Opcode 13 also writes condition field 0.
- R6: In register arithmetic (opcode 31, extended code in bits 9:1), bit 10 sets `ov_we_o` and bit 0 sets `cr_we_o` with `cr_field_o`=0. The codes are: 266 add (op 1, cin 0), 40 subtract-from (op 2, cin 1), 104 negate (op 3, cin 1), 235 multiply (op 4), 491 divide (op 5). The destination is bits 25:21, and the sources are bits 20:16 and 15:11.
- R7: The extended codes 138 (op 1), 136 (op 2) and 202 (op 1) use the stored carry as carry-in (`cin_sel_o`=2) and set `ca_we_o`. The OE and record rules of R6 apply to them as well.
- R8: Opcode 31 with bits 8:1 = 170, bit 0 clear and carry field 1 is op 1. It has `cin_sel_o`=3 (overflow flag), `ov_we_o`=1, `ov_from_cout_o`=1 and `ca_we_o`=0.
- R9: Compare (opcode 31, bits 10:1 = 0) and compare-immediate (opcode 11) give op 6 and no register write. They set `cr_we_o`, and `cr_field_o` is taken from bits 25:23.
- R10: Logical immediates (24/25 OR op 8, 26/27 XOR op 9, 28/29 AND op 7) write the register in bits 20:16 and read the one in bits 25:21. Only 28 and 29 write condition field 0; the others raise no flag enable.
- R11: Register logical forms (opcode 31, bits 10:1): 28 AND op 7, 444 OR op 8, 316 XOR op 9, 476 NAND op 10, 284 EQV op 11, 60 ANDC op 12, 412 ORC op 13. They use the R10 register roles, and bit 0 alone sets the condition field 0 write.
- R12: `imm_o` is sign-extended for opcodes 7, 8, 11, 12, 13 and 14, and zero-extended for 24, 26 and 28. Opcode 15 takes the sign-extended value shifted left 16, and 25, 27 and 29 take the zero-extended value shifted left 16. Every other form gives `imm_o`=0 with `use_imm_o`=0.
- R13: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arch_riscv_i | input | 1 | Instruction-set select from the machine state bit (1 = second set) |
| in_valid_i | input | 1 | Instruction word present |
| insn_i | input | 32 | Instruction word |
| out_valid_o | output | 1 | Record valid |
| illegal_o | output | 1 | Word not recognised |
| op_o | output | 4 | Operation class |
| rd_o | output | 5 | Destination register index |
| ra_o | output | 5 | First source register index |
| rb_o | output | 5 | Second source register index |
| rd_we_o | output | 1 | Destination register write enable |
| use_imm_o | output | 1 | Second operand is the immediate |
| imm_o | output | XLEN | Extended and shifted immediate |
| cin_sel_o | output | 2 | Carry-in: 0 zero, 1 one, 2 carry flag, 3 overflow flag |
| ca_we_o | output | 1 | Carry flag write enable |
| ov_we_o | output | 1 | Overflow flag write enable |
| ov_from_cout_o | output | 1 | Overflow flag receives the adder carry-out |
| cr_we_o | output | 1 | Condition-register field write enable |
| cr_field_o | output | 3 | Condition-register field index |

## Verification
The bench builds the block with `XLEN` set to 64 rather than the default 32. With the wider setting, sign and zero extension show in the upper 32 bits, so a missing extension or a wrong shift amount for the shifted immediates fails a check. It also separates a 32-bit shifted zero-extended value from a sign-extended one. Every listed encoding is run through the vector table with mixed OE and record bits, together with the reserved variants of the compare and extended-add forms.

// File: rtl/fxd_pkg.sv
package fxd_pkg;

    localparam int INSN_W = 32;
    localparam int PO_W   = 6;
    localparam int REG_W  = 5;
    localparam int CRF_W  = 3;
    localparam int IMM_W  = 16;

    typedef enum logic [3:0] {
        OP_NONE = 4'd0,
        OP_ADD  = 4'd1,
        OP_SUBF = 4'd2,
        OP_NEG  = 4'd3,
        OP_MUL  = 4'd4,
        OP_DIV  = 4'd5,
        OP_CMP  = 4'd6,
        OP_AND  = 4'd7,
        OP_OR   = 4'd8,
        OP_XOR  = 4'd9,
        OP_NAND = 4'd10,
        OP_EQV  = 4'd11,
        OP_ANDC = 4'd12,
        OP_ORC  = 4'd13
    } op_e;

    typedef enum logic [1:0] {
        CIN_ZERO = 2'd0,
        CIN_ONE  = 2'd1,
        CIN_CA   = 2'd2,
        CIN_OV   = 2'd3
    } cin_e;

    typedef enum logic [2:0] {
        IMM_NONE    = 3'd0,
        IMM_SEXT    = 3'd1,
        IMM_ZEXT    = 3'd2,
        IMM_SEXT_HI = 3'd3,
        IMM_ZEXT_HI = 3'd4
    } imm_e;

    typedef struct packed {
        op_e              op;
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] ra;
        logic [REG_W-1:0] rb;
        logic             rd_we;
        imm_e             ikind;
        logic [IMM_W-1:0] imm16;
        cin_e             cin;
        logic             ca_we;
        logic             ov_we;
        logic             ov_cout;
        logic             cr_we;
        logic [CRF_W-1:0] crf;
    } uop_t;

endpackage

// File: rtl/fxd_dform.sv
module fxd_dform
    import fxd_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    output logic              hit_o,
    output uop_t              uop_o
);

    logic [PO_W-1:0] po;
    assign po = insn_i[INSN_W-1 -: PO_W];

    always_comb begin
        uop_o       = '0;
        hit_o       = 1'b1;
        uop_o.imm16 = insn_i[IMM_W-1:0];
        uop_o.rd    = insn_i[25:21];
        uop_o.ra    = insn_i[20:16];
        case (po)
            6'd14: begin uop_o.op = OP_ADD;  uop_o.rd_we = 1'b1; uop_o.ikind = IMM_SEXT;    end
            6'd15: begin uop_o.op = OP_ADD;  uop_o.rd_we = 1'b1; uop_o.ikind = IMM_SEXT_HI; end
            6'd7:  begin uop_o.op = OP_MUL;  uop_o.rd_we = 1'b1; uop_o.ikind = IMM_SEXT;    end
            6'd12: begin
                uop_o.op = OP_ADD; uop_o.rd_we = 1'b1; uop_o.ikind = IMM_SEXT;
                uop_o.ca_we = 1'b1;
            end
            6'd13: begin
                uop_o.op = OP_ADD; uop_o.rd_we = 1'b1; uop_o.ikind = IMM_SEXT;
                uop_o.ca_we = 1'b1; uop_o.cr_we = 1'b1;
            end
            6'd8: begin
                uop_o.op = OP_SUBF; uop_o.rd_we = 1'b1; uop_o.ikind = IMM_SEXT;
                uop_o.ca_we = 1'b1; uop_o.cin = CIN_ONE;
            end
            6'd11: begin
                uop_o.op = OP_CMP; uop_o.rd = '0; uop_o.ikind = IMM_SEXT;
                uop_o.cr_we = 1'b1; uop_o.crf = insn_i[25:23];
            end
            6'd24, 6'd25, 6'd26, 6'd27, 6'd28, 6'd29: begin
                uop_o.rd    = insn_i[20:16];
                uop_o.ra    = insn_i[25:21];
                uop_o.rd_we = 1'b1;
                uop_o.ikind = po[0] ? IMM_ZEXT_HI : IMM_ZEXT;
                case (po[2:1])
                    2'b00:   uop_o.op = OP_OR;
                    2'b01:   uop_o.op = OP_XOR;
                    default: begin uop_o.op = OP_AND; uop_o.cr_we = 1'b1; end
                endcase
            end
            default: begin
                hit_o = 1'b0;
                uop_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/fxd_xform.sv
module fxd_xform
    import fxd_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    output logic              hit_o,
    output uop_t              uop_o
);

    localparam logic [PO_W-1:0] PO_EXT  = 6'd31;
    localparam logic [7:0]      XO_ADDX = 8'd170;

    logic [8:0] xo9;
    logic [9:0] xo10;
    logic [7:0] xo8;
    logic [1:0] cy;
    logic       oe, rc;

    assign xo9  = insn_i[9:1];
    assign xo10 = insn_i[10:1];
    assign xo8  = insn_i[8:1];
    assign cy   = insn_i[10:9];
    assign oe   = insn_i[10];
    assign rc   = insn_i[0];

    always_comb begin
        uop_o    = '0;
        hit_o    = 1'b1;
        uop_o.rd = insn_i[25:21];
        uop_o.ra = insn_i[20:16];
        uop_o.rb = insn_i[15:11];
        if (insn_i[INSN_W-1 -: PO_W] != PO_EXT) begin
            hit_o = 1'b0;
        end else if (xo8 == XO_ADDX && !rc) begin
            if (cy == 2'd1) begin
                uop_o.op      = OP_ADD;
                uop_o.rd_we   = 1'b1;
                uop_o.cin     = CIN_OV;
                uop_o.ov_we   = 1'b1;
                uop_o.ov_cout = 1'b1;
            end else begin
                hit_o = 1'b0;
            end
        end else begin
            uop_o.rd_we = 1'b1;
            uop_o.ov_we = oe;
            uop_o.cr_we = rc;
            case (xo9)
                9'd266: uop_o.op = OP_ADD;
                9'd40:  begin uop_o.op = OP_SUBF; uop_o.cin = CIN_ONE; end
                9'd104: begin uop_o.op = OP_NEG;  uop_o.cin = CIN_ONE; end
                9'd235: uop_o.op = OP_MUL;
                9'd491: uop_o.op = OP_DIV;
                9'd138: begin uop_o.op = OP_ADD;  uop_o.cin = CIN_CA; uop_o.ca_we = 1'b1; end
                9'd136: begin uop_o.op = OP_SUBF; uop_o.cin = CIN_CA; uop_o.ca_we = 1'b1; end
                9'd202: begin uop_o.op = OP_ADD;  uop_o.cin = CIN_CA; uop_o.ca_we = 1'b1; end
                default: begin
                    uop_o.ov_we = 1'b0;
                    uop_o.rd    = insn_i[20:16];
                    uop_o.ra    = insn_i[25:21];
                    case (xo10)
                        10'd28:  uop_o.op = OP_AND;
                        10'd444: uop_o.op = OP_OR;
                        10'd316: uop_o.op = OP_XOR;
                        10'd476: uop_o.op = OP_NAND;
                        10'd284: uop_o.op = OP_EQV;
                        10'd60:  uop_o.op = OP_ANDC;
                        10'd412: uop_o.op = OP_ORC;
                        10'd0: begin
                            uop_o.op    = OP_CMP;
                            uop_o.rd    = '0;
                            uop_o.ra    = insn_i[20:16];
                            uop_o.rd_we = 1'b0;
                            uop_o.cr_we = 1'b1;
                            uop_o.crf   = insn_i[25:23];
                            if (rc) hit_o = 1'b0;
                        end
                        default: hit_o = 1'b0;
                    endcase
                end
            endcase
            if (!hit_o) uop_o = '0;
        end
    end

endmodule

// File: rtl/fxu_decode.sv
module fxu_decode
    import fxd_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  arch_riscv_i,
    input  logic                  in_valid_i,
    input  logic [INSN_W-1:0]     insn_i,
    output logic                  out_valid_o,
    output logic                  illegal_o,
    output logic [3:0]            op_o,
    output logic [REG_W-1:0]      rd_o,
    output logic [REG_W-1:0]      ra_o,
    output logic [REG_W-1:0]      rb_o,
    output logic                  rd_we_o,
    output logic                  use_imm_o,
    output logic [XLEN-1:0]       imm_o,
    output logic [1:0]            cin_sel_o,
    output logic                  ca_we_o,
    output logic                  ov_we_o,
    output logic                  ov_from_cout_o,
    output logic                  cr_we_o,
    output logic [CRF_W-1:0]      cr_field_o
);

    localparam int EXT_W = XLEN - IMM_W;

    typedef struct packed {
        logic            vld;
        logic            ill;
        uop_t            u;
        logic [XLEN-1:0] imm;
    } stage_t;

    logic   d_hit, x_hit;
    uop_t   d_uop, x_uop;
    stage_t stage_d, stage_q;
    logic [XLEN-1:0] sx, zx;

    fxd_dform u_dform (.insn_i(insn_i), .hit_o(d_hit), .uop_o(d_uop));
    fxd_xform u_xform (.insn_i(insn_i), .hit_o(x_hit), .uop_o(x_uop));

    always_comb begin
        stage_d = '0;
        sx      = '0;
        zx      = '0;
        if (in_valid_i) begin
            stage_d.vld = 1'b1;
            if (arch_riscv_i || !(d_hit || x_hit)) begin
                stage_d.ill = 1'b1;
            end else begin
                stage_d.u = d_hit ? d_uop : x_uop;
                sx = {{EXT_W{stage_d.u.imm16[IMM_W-1]}}, stage_d.u.imm16};
                zx = {{EXT_W{1'b0}}, stage_d.u.imm16};
                case (stage_d.u.ikind)
                    IMM_SEXT:    stage_d.imm = sx;
                    IMM_ZEXT:    stage_d.imm = zx;
                    IMM_SEXT_HI: stage_d.imm = sx << IMM_W;
                    IMM_ZEXT_HI: stage_d.imm = zx << IMM_W;
                    default:     stage_d.imm = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign out_valid_o    = stage_q.vld;
    assign illegal_o      = stage_q.ill;
    assign op_o           = stage_q.u.op;
    assign rd_o           = stage_q.u.rd;
    assign ra_o           = stage_q.u.ra;
    assign rb_o           = stage_q.u.rb;
    assign rd_we_o        = stage_q.u.rd_we;
    assign use_imm_o      = (stage_q.u.ikind != IMM_NONE);
    assign imm_o          = stage_q.imm;
    assign cin_sel_o      = stage_q.u.cin;
    assign ca_we_o        = stage_q.u.ca_we;
    assign ov_we_o        = stage_q.u.ov_we;
    assign ov_from_cout_o = stage_q.u.ov_cout;
    assign cr_we_o        = stage_q.u.cr_we;
    assign cr_field_o     = stage_q.u.crf;

endmodule

// File: rtl/fxu_decode_chk.sv
module fxu_decode_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       arch_riscv_i,
    input logic       in_valid_i,
    input logic       out_valid_o,
    input logic       illegal_o,
    input logic [3:0] op_o,
    input logic       rd_we_o,
    input logic [1:0] cin_sel_o,
    input logic       ca_we_o,
    input logic       ov_we_o,
    input logic       ov_from_cout_o,
    input logic       cr_we_o,
    input logic [2:0] cr_field_o
);

    // R1: record valid tracks the previous cycle's input valid
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid_o == $past(in_valid_i)));

    // R1: an empty slot carries no enables
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o |-> !(illegal_o || rd_we_o || ca_we_o || ov_we_o || cr_we_o));

    // R2: second instruction set always illegal
    a_r2_other_isa: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid_i) && $past(arch_riscv_i)) |-> illegal_o);

    // R3: illegal words write nothing
    a_r3_illegal_inert: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !(rd_we_o || ca_we_o || ov_we_o || cr_we_o) && op_o == 4'd0);

    // R8: carry-out into overflow only with overflow as carry-in and no carry write
    a_r8_ov_cout: assert property (@(posedge clk) disable iff (!rst_n)
        ov_from_cout_o |-> (ov_we_o && !ca_we_o && cin_sel_o == 2'd3));

    // R6/R10/R11: non-compare record forms target field 0
    a_r6_cr0_only: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_we_o && op_o != 4'd6) |-> (cr_field_o == 3'd0));

    // R9: compare never writes a register
    a_r9_cmp_no_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (op_o == 4'd6) |-> (!rd_we_o && cr_we_o));

endmodule

bind fxu_decode fxu_decode_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .arch_riscv_i   (arch_riscv_i),
    .in_valid_i     (in_valid_i),
    .out_valid_o    (out_valid_o),
    .illegal_o      (illegal_o),
    .op_o           (op_o),
    .rd_we_o        (rd_we_o),
    .cin_sel_o      (cin_sel_o),
    .ca_we_o        (ca_we_o),
    .ov_we_o        (ov_we_o),
    .ov_from_cout_o (ov_from_cout_o),
    .cr_we_o        (cr_we_o),
    .cr_field_o     (cr_field_o)
);

// File: tb/tb_fxu_decode.sv
`timescale 1ns/1ps
module tb_fxu_decode;

    localparam int XLEN = 64;
    localparam int NV   = 36;

    function automatic logic [31:0] fd(input int po, input int rt, input int ra, input int imm);
        return {po[5:0], rt[4:0], ra[4:0], imm[15:0]};
    endfunction
    function automatic logic [31:0] fxo(input int rt, input int ra, input int rb, input int oe,
                                        input int xo, input int rc);
        return {6'd31, rt[4:0], ra[4:0], rb[4:0], oe[0], xo[8:0], rc[0]};
    endfunction
    function automatic logic [31:0] fx(input int rs, input int ra, input int rb, input int xo,
                                       input int rc);
        return {6'd31, rs[4:0], ra[4:0], rb[4:0], xo[9:0], rc[0]};
    endfunction
    function automatic logic [31:0] fz(input int cy);
        return {6'd31, 5'd3, 5'd4, 5'd5, cy[1:0], 8'd170, 1'b0};
    endfunction
    // {illegal, op[3:0], rd_we, cin[1:0], ca_we, ov_we, ov_cout, cr_we, crf[2:0]}
    function automatic logic [14:0] ef(input int il, input int op, input int we, input int ci,
                                       input int ca, input int ov, input int oc, input int cr,
                                       input int cf);
        return {il[0], op[3:0], we[0], ci[1:0], ca[0], ov[0], oc[0], cr[0], cf[2:0]};
    endfunction

    localparam logic [14:0] ILL = 15'h4000;

    localparam logic [31:0] VIN [NV] = '{
        fd(14,3,4,'hFFFE), fd(15,3,4,'h8000), fd(7,3,4,5), fd(12,3,4,'h10),
        fd(13,3,4,'hFFFF), fd(8,3,4,1), fd(11,20,4,'h8001), fd(24,6,9,'h8001),
        fd(25,6,9,'h8001), fd(26,6,9,'hFFFF), fd(27,6,9,'h1234), fd(28,6,9,'hF0F0),
        fd(29,6,9,'hFFFF),
        fxo(3,4,5,0,266,0), fxo(3,4,5,1,266,1), fxo(3,4,5,0,40,0), fxo(3,4,5,0,138,1),
        fxo(3,4,5,1,136,0), fxo(3,4,0,0,202,0), fxo(3,4,0,1,104,1), fxo(3,4,5,1,235,0),
        fxo(3,4,5,0,491,1),
        fz(1), fz(0),
        fx(28,4,5,0,0), fx(6,9,5,28,1), fx(6,9,5,444,0), fx(6,9,5,316,1),
        fx(6,9,5,476,0), fx(6,9,5,284,1), fx(6,9,5,60,0), fx(6,9,5,412,1),
        fx(6,9,5,1,0), fd(0,0,0,0), fx(28,4,5,0,1), fz(2)
    };

    localparam logic [14:0] VEXP [NV] = '{
        ef(0,1,1,0,0,0,0,0,0), ef(0,1,1,0,0,0,0,0,0), ef(0,4,1,0,0,0,0,0,0), ef(0,1,1,0,1,0,0,0,0),
        ef(0,1,1,0,1,0,0,1,0), ef(0,2,1,1,1,0,0,0,0), ef(0,6,0,0,0,0,0,1,5), ef(0,8,1,0,0,0,0,0,0),
        ef(0,8,1,0,0,0,0,0,0), ef(0,9,1,0,0,0,0,0,0), ef(0,9,1,0,0,0,0,0,0), ef(0,7,1,0,0,0,0,1,0),
        ef(0,7,1,0,0,0,0,1,0),
        ef(0,1,1,0,0,0,0,0,0), ef(0,1,1,0,0,1,0,1,0), ef(0,2,1,1,0,0,0,0,0), ef(0,1,1,2,1,0,0,1,0),
        ef(0,2,1,2,1,1,0,0,0), ef(0,1,1,2,1,0,0,0,0), ef(0,3,1,1,0,1,0,1,0), ef(0,4,1,0,0,1,0,0,0),
        ef(0,5,1,0,0,0,0,1,0),
        ef(0,1,1,3,0,1,1,0,0), ILL,
        ef(0,6,0,0,0,0,0,1,7), ef(0,7,1,0,0,0,0,1,0), ef(0,8,1,0,0,0,0,0,0), ef(0,9,1,0,0,0,0,1,0),
        ef(0,10,1,0,0,0,0,0,0), ef(0,11,1,0,0,0,0,1,0), ef(0,12,1,0,0,0,0,0,0), ef(0,13,1,0,0,0,0,1,0),
        ILL, ILL, ILL, ILL
    };

    localparam logic [63:0] VIMM [NV] = '{
        64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_8000_0000, 64'h5, 64'h10,
        64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'hFFFF_FFFF_FFFF_8001, 64'h8001,
        64'h0000_0000_8001_0000, 64'hFFFF, 64'h1234_0000, 64'hF0F0,
        64'h0000_0000_FFFF_0000,
        64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0,
        64'h0, 64'h0,
        64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0,
        64'h0, 64'h0, 64'h0, 64'h0
    };

    localparam string VREQ [NV] = '{
        "R4", "R12", "R4", "R5", "R5", "R5", "R9", "R10", "R12", "R10", "R10", "R10", "R12",
        "R6", "R6", "R6", "R7", "R7", "R7", "R6", "R6", "R6",
        "R8", "R3",
        "R9", "R11", "R11", "R11", "R11", "R11", "R11", "R11",
        "R3", "R3", "R3", "R3"
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            arch_riscv_i = 1'b0;
    logic            in_valid_i = 1'b0;
    logic [31:0]     insn_i = '0;
    logic            out_valid_o, illegal_o, rd_we_o, use_imm_o;
    logic [3:0]      op_o;
    logic [4:0]      rd_o, ra_o, rb_o;
    logic [XLEN-1:0] imm_o;
    logic [1:0]      cin_sel_o;
    logic            ca_we_o, ov_we_o, ov_from_cout_o, cr_we_o;
    logic [2:0]      cr_field_o;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    fxu_decode #(.XLEN(XLEN)) dut (
        .clk(clk), .rst_n(rst_n), .arch_riscv_i(arch_riscv_i), .in_valid_i(in_valid_i),
        .insn_i(insn_i), .out_valid_o(out_valid_o), .illegal_o(illegal_o), .op_o(op_o),
        .rd_o(rd_o), .ra_o(ra_o), .rb_o(rb_o), .rd_we_o(rd_we_o), .use_imm_o(use_imm_o),
        .imm_o(imm_o), .cin_sel_o(cin_sel_o), .ca_we_o(ca_we_o), .ov_we_o(ov_we_o),
        .ov_from_cout_o(ov_from_cout_o), .cr_we_o(cr_we_o), .cr_field_o(cr_field_o)
    );

    function automatic logic [14:0] flags();
        return {illegal_o, op_o, rd_we_o, cin_sel_o, ca_we_o, ov_we_o, ov_from_cout_o,
                cr_we_o, cr_field_o};
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic v, input logic arch, input logic [31:0] w);
        @(negedge clk);
        in_valid_i   = v;
        arch_riscv_i = arch;
        insn_i       = w;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R13: reset state, even with a valid word applied
        in_valid_i = 1'b1;
        insn_i     = fd(14, 3, 4, 1);
        repeat (3) @(negedge clk);
        chk("R13", "valid", {63'd0, out_valid_o}, 64'd0);
        chk("R13", "flags", {49'd0, flags()}, 64'd0);
        chk("R13", "imm", imm_o, 64'd0);
        in_valid_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // table of encodings in POWER mode
        for (int i = 0; i < NV; i++) begin
            apply(1'b1, 1'b0, VIN[i]);
            chk(VREQ[i], "valid", {63'd0, out_valid_o}, 64'd1);
            chk(VREQ[i], "flags", {49'd0, flags()}, {49'd0, VEXP[i]});
            chk(VREQ[i], "imm", imm_o, VIMM[i]);
        end

        // R6: register roles in arithmetic forms
        apply(1'b1, 1'b0, fxo(3, 4, 5, 0, 266, 0));
        chk("R6", "regs", {49'd0, rd_o, ra_o, rb_o}, {49'd0, 5'd3, 5'd4, 5'd5});
        chk("R6", "use_imm", {63'd0, use_imm_o}, 64'd0);

        // R10: logical immediate swaps destination and source
        apply(1'b1, 1'b0, fd(24, 6, 9, 7));
        chk("R10", "regs", {54'd0, rd_o, ra_o}, {54'd0, 5'd9, 5'd6});
        chk("R12", "use_imm", {63'd0, use_imm_o}, 64'd1);

        // R11: register logical roles
        apply(1'b1, 1'b0, fx(6, 9, 5, 444, 0));
        chk("R11", "regs", {49'd0, rd_o, ra_o, rb_o}, {49'd0, 5'd9, 5'd6, 5'd5});

        // R2: same words in the second instruction-set mode
        apply(1'b1, 1'b1, fd(13, 3, 4, 'hFFFF));
        chk("R2", "flags", {49'd0, flags()}, {49'd0, ILL});
        chk("R2", "imm", imm_o, 64'd0);
        apply(1'b1, 1'b1, fz(1));
        chk("R2", "flags", {49'd0, flags()}, {49'd0, ILL});

        // R1: a bubble after a valid word
        apply(1'b0, 1'b0, fd(12, 3, 4, 1));
        chk("R1", "valid", {63'd0, out_valid_o}, 64'd0);
        chk("R1", "flags", {49'd0, flags()}, 64'd0);
        apply(1'b1, 1'b0, fd(12, 3, 4, 1));
        chk("R1", "valid", {63'd0, out_valid_o}, 64'd1);

        // R13: reset asserted mid-run clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R13", "flags", {48'd0, out_valid_o, flags()}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule